// File: doc/BRIEF.md
# Serial Receive Inhibit Controller

This block guards a very shallow receive queue at the far end of a serial word link. A deserializer presents each complete word with a one-cycle strobe. The block stores it in a two-entry queue and drives a ready line back toward the remote transmitter. Whenever the local consumer asks for service, the block first pulls that ready line low. After one settling cycle it examines the queue. If the queue is empty, it raises the ready line again and the service ends. If the queue holds data, ready stays low and the oldest word is offered on a valid/ready output stream until the consumer takes it.

The ready line is therefore low around every inspection of the queue, not only when the queue is full. It returns high only after an inspection finds nothing waiting. A sticky error flag records two conditions: an inspection that finds the queue completely full, and a word that arrives when there is no room for it. Software-free clearing is done with a single pulse input.

Output stream rules: `drain_valid` rises only inside a service. Once it is high, `drain_valid` and `drain_word` hold unchanged until `drain_ready` is seen high on a clock edge; the consumer may stall indefinitely. The input strobe has no back-pressure of its own. The ready line is the only flow control toward the sender, and a word that finds the queue full is lost.

Top module: `rx_inhibit_ctrl`

## Requirements
- R1: The queue holds at most DEPTH (default 2) words. A strobed word is stored whenever the queue has room, whatever the level of the ready line, including a word arriving while a service is starting. Words leave in arrival order.
- R2: After reset, `link_ready` is 0, `drain_valid` is 0 and `overflow_err` is 0.
- R3: When `service_req` is sampled high with no service in progress, `link_ready` is 0 from the next cycle on and stays 0 through the inspection cycle that follows.
- R4: If the inspection (the second cycle after the request edge) finds the queue empty, `link_ready` is 1 from that edge on and the service ends. `link_ready` rises on no other occasion.
- R5: If the inspection finds data, the oldest word appears with `drain_valid`=1 at that edge. `link_ready` stays 0 while it is offered and after it is taken, until a later service finds the queue empty.
- R6: While `drain_valid` is 1 and `drain_ready` is 0, `drain_valid` and `drain_word` are held. The word is removed on the edge where both are 1, and `drain_valid` is 0 afterward.
- R7: An inspection that finds the queue full (DEPTH words) sets `overflow_err`, visible together with the first `drain_valid`.
- R8: A word strobed while the queue is full is discarded and sets `overflow_err` from the next cycle.
- R9: `overflow_err` stays 1 until `err_clear` is sampled high. A new error event in the same cycle as `err_clear` keeps it at 1.
- R10: `service_req` has no effect while a service is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_strobe | input | 1 | One-cycle marker for a received word |
| rx_word | input | 32 | Received word |
| link_ready | output | 1 | 1: sender may transmit; 0: sender must hold off |
| service_req | input | 1 | Consumer asks for a service cycle |
| drain_valid | output | 1 | Drained word is offered |
| drain_word | output | 32 | Oldest stored word |
| drain_ready | input | 1 | Consumer acknowledges the offered word |
| overflow_err | output | 1 | Sticky error flag |
| err_clear | input | 1 | Pulse to clear the error flag |

## Verification
A table drives fill levels of zero, one, two and three words, each followed by services until an empty inspection. The zero case separates a ready rise on an empty check from any spurious offer. The single word shows ordering without error. The full case distinguishes the inspection-time error from the drop-time error. The three-word case proves the extra word is lost rather than overwriting. Directed cases cover a word landing during the inhibit cycle, a consumer stall, a request made mid-service, and clear colliding with a new error.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  typedef enum logic [1:0] {
    SV_IDLE    = 2'd0,
    SV_INHIBIT = 2'd1,
    SV_CHECK   = 2'd2,
    SV_OFFER   = 2'd3
  } svc_state_t;
endpackage

// File: rtl/rxi_queue.sv
module rxi_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         nonempty,
  output logic                         dropped
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          take, give;

  assign full     = (level == CW'(DEPTH));
  assign nonempty = (level != '0);
  assign take     = push && !full;
  assign give     = pop && nonempty;
  assign dropped  = push && full;
  assign dout     = slots[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (take) begin
        slots[wp] <= din;
        wp        <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (give) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (take && !give)      level <= level + 1'b1;
      else if (give && !take) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/rxi_sequencer.sv
module rxi_sequencer
  import rxi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       service_req,
  input  logic       q_nonempty,
  input  logic       q_full,
  input  logic       drain_ready,
  output logic       link_ready,
  output logic       drain_valid,
  output logic       pop,
  output logic       full_seen,
  output svc_state_t state
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SV_IDLE;
      link_ready <= 1'b0;
    end else begin
      unique case (state)
        SV_IDLE: if (service_req) begin
          link_ready <= 1'b0;
          state      <= SV_INHIBIT;
        end
        SV_INHIBIT: state <= SV_CHECK;
        SV_CHECK: if (q_nonempty) begin
          state <= SV_OFFER;
        end else begin
          link_ready <= 1'b1;
          state      <= SV_IDLE;
        end
        SV_OFFER: if (drain_ready) state <= SV_IDLE;
        default: state <= SV_IDLE;
      endcase
    end
  end

  assign drain_valid = (state == SV_OFFER);
  assign pop         = drain_valid && drain_ready;
  assign full_seen   = (state == SV_CHECK) && q_nonempty && q_full;
endmodule

// File: rtl/rxi_err_flag.sv
module rxi_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_a,
  input  logic set_b,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag && !clr) || set_a || set_b;
  end
endmodule

// File: rtl/rx_inhibit_ctrl.sv
module rx_inhibit_ctrl
  import rxi_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_strobe,
  input  logic [W-1:0] rx_word,
  output logic         link_ready,
  input  logic         service_req,
  output logic         drain_valid,
  output logic [W-1:0] drain_word,
  input  logic         drain_ready,
  output logic         overflow_err,
  input  logic         err_clear
);
  localparam int CW = $clog2(DEPTH+1);

  logic          q_pop, q_full, q_nonempty, q_drop, full_seen;
  logic [CW-1:0] q_level;
  svc_state_t    seq_state;

  rxi_queue #(.W(W), .DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .push(rx_strobe), .din(rx_word),
    .pop(q_pop), .dout(drain_word), .level(q_level), .full(q_full),
    .nonempty(q_nonempty), .dropped(q_drop)
  );

  rxi_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .service_req(service_req),
    .q_nonempty(q_nonempty), .q_full(q_full), .drain_ready(drain_ready),
    .link_ready(link_ready), .drain_valid(drain_valid), .pop(q_pop),
    .full_seen(full_seen), .state(seq_state)
  );

  rxi_err_flag err_i (
    .clk(clk), .rst_n(rst_n), .set_a(full_seen), .set_b(q_drop),
    .clr(err_clear), .flag(overflow_err)
  );
endmodule

// File: rtl/rx_inhibit_ctrl_chk.sv
module rx_inhibit_ctrl_chk
  import rxi_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_strobe,
  input logic                       link_ready,
  input logic                       service_req,
  input logic                       drain_valid,
  input logic [W-1:0]               drain_word,
  input logic                       drain_ready,
  input logic                       overflow_err,
  input logic                       err_clear,
  input logic [$clog2(DEPTH+1)-1:0] q_level,
  input svc_state_t                 seq_state
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= ($clog2(DEPTH+1))'(DEPTH));

  a_r3_inhibit_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ready) |-> $past(service_req));

  a_r4_rise_after_empty_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(seq_state == SV_CHECK && q_level == '0));

  a_r5_low_while_offered: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> !link_ready);

  a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid && !drain_ready |=> drain_valid && $stable(drain_word));

  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe && q_level == ($clog2(DEPTH+1))'(DEPTH) && !(drain_valid && drain_ready)
      |=> overflow_err);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err && !err_clear |=> overflow_err);
endmodule

bind rx_inhibit_ctrl rx_inhibit_ctrl_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .link_ready(link_ready),
  .service_req(service_req), .drain_valid(drain_valid), .drain_word(drain_word),
  .drain_ready(drain_ready), .overflow_err(overflow_err), .err_clear(err_clear),
  .q_level(q_level), .seq_state(seq_state)
);

// File: tb/rx_inhibit_ctrl_tb_top.sv
module rx_inhibit_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_strobe = 1'b0;
  logic [31:0] rx_word = '0;
  logic        link_ready, drain_valid, overflow_err;
  logic [31:0] drain_word;
  logic        service_req = 1'b0, drain_ready = 1'b0, err_clear = 1'b0;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rx_inhibit_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_word(rx_word),
    .link_ready(link_ready), .service_req(service_req),
    .drain_valid(drain_valid), .drain_word(drain_word),
    .drain_ready(drain_ready), .overflow_err(overflow_err), .err_clear(err_clear)
  );

  typedef struct packed { logic [31:0] n; logic [31:0] base; } vec_t;
  localparam vec_t VEC [5] = '{
    '{32'd0, 32'h1000_0000}, '{32'd1, 32'hA5A5_0000}, '{32'd2, 32'h2222_0000},
    '{32'd3, 32'h3C3C_0000}, '{32'd1, 32'h0F0F_0000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(logic [31:0] w);
    rx_strobe = 1'b1; rx_word = w;
    step();
    rx_strobe = 1'b0;
  endtask

  task automatic clear_err();
    err_clear = 1'b1; step(); err_clear = 1'b0;
  endtask

  // one service that must find data; consumer takes it at once
  task automatic svc_word(logic [31:0] w, logic e);
    service_req = 1'b1; step(); service_req = 1'b0;
    check("R3 ready low after request", link_ready, 0);
    step();
    check("R3 ready low in check", link_ready, 0);
    step();
    check("R5 word offered", drain_valid, 1);
    check("R5 oldest word", drain_word, w);
    check("R7 error at inspection", overflow_err, e);
    drain_ready = 1'b1; step(); drain_ready = 1'b0;
    check("R6 valid drops after take", drain_valid, 0);
    check("R5 ready stays low after take", link_ready, 0);
  endtask

  task automatic svc_empty();
    service_req = 1'b1; step(); service_req = 1'b0;
    check("R3 ready low after request", link_ready, 0);
    step();
    check("R4 not yet high", link_ready, 0);
    step();
    check("R4 ready high after empty check", link_ready, 1);
    check("R4 nothing offered", drain_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check("R2 ready after reset", link_ready, 0);
    check("R2 valid after reset", drain_valid, 0);
    check("R2 err after reset", overflow_err, 0);
    rst_n = 1'b1; step();

    foreach (VEC[k]) begin
      clear_err();
      for (int i = 0; i < int'(VEC[k].n); i++) push(VEC[k].base + 32'(i));
      if (VEC[k].n == 3) check("R8 drop flags error", overflow_err, 1);
      for (int i = 0; i < ((VEC[k].n > 2) ? 2 : int'(VEC[k].n)); i++)
        svc_word(VEC[k].base + 32'(i), VEC[k].n >= 2);
      svc_empty();
      check("R1 R9 final error level", overflow_err, 32'(VEC[k].n >= 2));
    end

    // R1: word landing during the inhibit cycle is kept
    clear_err();
    service_req = 1'b1; step(); service_req = 1'b0;
    rx_strobe = 1'b1; rx_word = 32'hBEEF_0001; step(); rx_strobe = 1'b0;
    step();
    check("R1 in-flight word stored", drain_valid, 1);
    check("R1 in-flight word value", drain_word, 32'hBEEF_0001);
    // R6 stall, R10 request during service
    service_req = 1'b1; step(); service_req = 1'b0;
    step();
    check("R6 held valid", drain_valid, 1);
    check("R6 held word", drain_word, 32'hBEEF_0001);
    drain_ready = 1'b1; step(); drain_ready = 1'b0;
    repeat (3) step();
    check("R10 mid-service request ignored", link_ready, 0);
    check("R10 no offer", drain_valid, 0);
    svc_empty();

    // R9: set wins over clear, then clear works
    clear_err();
    push(32'h1); push(32'h2);
    rx_strobe = 1'b1; rx_word = 32'h3; err_clear = 1'b1; step();
    rx_strobe = 1'b0; err_clear = 1'b0;
    check("R9 set wins over clear", overflow_err, 1);
    repeat (2) step();
    check("R9 sticky", overflow_err, 1);
    clear_err();
    check("R9 clear", overflow_err, 0);
    svc_word(32'h1, 1'b1);
    svc_word(32'h2, 1'b1);
    svc_empty();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule